// File: doc/BRIEF.md
# DRAM Rank Power-Down Sequencer

This block decides, cycle by cycle, whether each rank of one memory channel has its clock enable raised and whether commands may be steered to it with chip select. A rank that stays idle for a programmed number of cycles is put into power-down. The mode input picks one of two ways in. In the active way the clock enable simply drops. In the precharge way a precharge-all request goes out first, and the clock enable drops after a fixed settle wait. When the access logic asks for a rank that is powered down, the clock enable rises again. The access is granted only after a fixed exit delay.

Refresh is sequenced for the whole channel. Every populated rank is woken, all pages are closed with a precharge-all, and a single refresh command is issued. After a fixed refresh wait, every idle rank is put back into power-down. While the package reports a deep idle state, the channel is placed in self-refresh. All clock enables are held low, and refresh requests are dropped because the devices refresh themselves. Leaving deep idle raises every populated rank again, and access resumes after the exit delay. Rank slots marked as not populated never see an asserted clock enable, chip select, precharge request or grant.

Top module: `rank_pd_seq`

## Requirements
- R1: While reset is held, every populated rank has `cke` and `cs_en` high, and `pre_all`, `ref_cmd`, `sr_req` and `rank_ready` are all low.
- R2: For a rank whose `rank_present` bit is 0, `cke`, `cs_en`, `pre_all` and `rank_ready` stay 0 in every mode, including during refresh and self-refresh.
- R3: An awake rank whose `rank_busy` is low for `idle_limit` consecutive clock edges starts power-down entry on the last of those edges. A limit of 0 acts as 1. In active mode `cke` is low after that edge.
- R4: In active mode (`pd_precharge` = 0), power-down entry raises no `pre_all` for that rank.
- R5: In precharge mode (`pd_precharge` = 1), power-down entry raises `pre_all` for that rank for exactly one cycle, right after the entry edge. `cke` stays high for PRE_DLY more edges and then drops.
- R6: When `rank_busy` rises for a powered-down rank, `cke` is high after the next edge. `rank_ready` follows EXIT_DLY edges later. `rank_ready` is never high while `cke` is low.
- R7: A pulse on `ref_req` leads to exactly one single-cycle `ref_cmd`. Before it, `pre_all` is raised for all populated ranks together, and during it every populated rank has `cke` high.
- R8: REF_DLY edges after the `ref_cmd` cycle, every populated rank is still awake. One edge later, every idle populated rank has `cke` low.
- R9: While `deep_idle` is high, the channel enters self-refresh: `sr_req` goes high with every `cke` low. A `ref_req` seen while in self-refresh produces no `ref_cmd`, then or after exit.
- R10: The edge after `deep_idle` falls, `sr_req` is low and every populated rank has `cke` high. A busy rank receives `rank_ready` EXIT_DLY edges after that.
- R11: No `rank_ready` is given while a refresh or self-refresh sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rank_present | input | NUM_RANKS | One bit per rank slot, 1 when populated |
| pd_precharge | input | 1 | Power-down mode: 0 active, 1 precharge |
| idle_limit | input | IDLE_W | Idle cycles before power-down entry (0 acts as 1) |
| ref_req | input | 1 | Refresh request pulse or level |
| deep_idle | input | 1 | Package is in a deep idle state |
| rank_busy | input | NUM_RANKS | Access pending for each rank |
| cke | output | NUM_RANKS | Clock enable for each rank |
| cs_en | output | NUM_RANKS | Chip select may be driven to this rank |
| pre_all | output | NUM_RANKS | Precharge-all request for each rank |
| ref_cmd | output | 1 | Refresh command request, one cycle |
| sr_req | output | 1 | Self-refresh request |
| rank_ready | output | NUM_RANKS | Access granted to a busy, awake rank |

## Verification
Most faults in the per-rank state would show up as the wrong number of edges between the end of activity and the fall of `cke`. They could also show as a stray or missing `pre_all`, or as `rank_ready` arriving before or after EXIT_DLY edges, and all of these are visible within a dozen cycles of the stimulus. Faults in the channel sequence would show at `ref_cmd`: a rank still asleep, no precharge-all beforehand, a repeated pulse, or ranks left awake one edge after the refresh wait. Self-refresh faults would appear as a clock enable high under `sr_req`, a refresh slipping through after exit, or a late grant. A slot marked empty that ever carries a high output is flagged on the cycle it happens.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

   // per-rank power state
   typedef enum logic [1:0] {
      RK_UP   = 2'd0,
      RK_PRE  = 2'd1,
      RK_PD   = 2'd2,
      RK_EXIT = 2'd3
   } rank_st_e;

   // channel-wide sequence state
   typedef enum logic [3:0] {
      CH_RUN   = 4'd0,
      CH_WAKE  = 4'd1,
      CH_PRE   = 4'd2,
      CH_REF   = 4'd3,
      CH_RWAIT = 4'd4,
      CH_SWAKE = 4'd5,
      CH_SPRE  = 4'd6,
      CH_SHOLD = 4'd7,
      CH_SEXIT = 4'd8
   } chan_st_e;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pdseq_rank.sv
module pdseq_rank
   import pdseq_pkg::*;
#(
   parameter int IDLE_W   = 8,
   parameter int EXIT_DLY = 3,
   parameter int PRE_DLY  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              pd_precharge,
   input  logic [IDLE_W-1:0] idle_limit,
   input  logic              wake,
   input  logic              sleep,
   output logic              rank_cke,
   output logic              rank_up,
   output logic              rank_in_pre,
   output logic              pre_pulse
);

   localparam int MAXD  = max_of3(EXIT_DLY, PRE_DLY, 1);
   localparam int CNT_W = $clog2(MAXD + 1);
   localparam logic [CNT_W-1:0] EXIT_LAST = CNT_W'(EXIT_DLY - 1);
   localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_DLY - 1);

   rank_st_e          st;
   logic [IDLE_W-1:0] idle_cnt;
   logic [CNT_W-1:0]  cnt;
   logic              idle_hit;

   // the current idle cycle completes the programmed run (0 behaves as 1)
   assign idle_hit = ({1'b0, idle_cnt} + (IDLE_W+1)'(1)) >= {1'b0, idle_limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RK_UP;
         idle_cnt <= '0;
         cnt      <= '0;
      end else begin
         case (st)
            RK_UP: begin
               if (sleep && !busy) begin
                  st       <= RK_PD;
                  idle_cnt <= '0;
               end else if (busy || wake) begin
                  idle_cnt <= '0;
               end else if (idle_hit) begin
                  idle_cnt <= '0;
                  cnt      <= '0;
                  st       <= pd_precharge ? RK_PRE : RK_PD;
               end else if (idle_cnt != '1) begin
                  idle_cnt <= idle_cnt + 1'b1;
               end
            end
            RK_PRE: begin
               if (busy || wake) begin
                  st <= RK_UP;
               end else if (cnt == PRE_LAST) begin
                  st <= RK_PD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RK_PD: begin
               if (busy || wake) begin
                  st  <= RK_EXIT;
                  cnt <= '0;
               end
            end
            RK_EXIT: begin
               if (cnt == EXIT_LAST) begin
                  st       <= RK_UP;
                  idle_cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= RK_UP;
         endcase
      end
   end

   assign rank_cke    = (st != RK_PD);
   assign rank_up     = (st == RK_UP);
   assign rank_in_pre = (st == RK_PRE);
   assign pre_pulse   = (st == RK_PRE) && (cnt == '0);

endmodule

// File: rtl/pdseq_chan.sv
module pdseq_chan
   import pdseq_pkg::*;
#(
   parameter int EXIT_DLY = 3,
   parameter int PRE_DLY  = 2,
   parameter int REF_DLY  = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ref_req,
   input  logic deep_idle,
   input  logic all_up,
   output logic wake,
   output logic sleep,
   output logic chan_pre,
   output logic ref_cmd,
   output logic run,
   output logic sr_hold,
   output logic sr_exit
);

   localparam int MAXD  = max_of3(EXIT_DLY, PRE_DLY, REF_DLY);
   localparam int CNT_W = $clog2(MAXD + 1);
   localparam logic [CNT_W-1:0] EXIT_LAST = CNT_W'(EXIT_DLY - 1);
   localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_DLY - 1);
   localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(REF_DLY - 1);

   chan_st_e         st;
   logic [CNT_W-1:0] cnt;
   logic             ref_pend;

   // pending refresh: dropped in self-refresh, consumed by the command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_pend <= 1'b0;
      end else if (st == CH_SHOLD) begin
         ref_pend <= 1'b0;
      end else if (st == CH_REF) begin
         ref_pend <= ref_req;
      end else begin
         ref_pend <= ref_pend | ref_req;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= CH_RUN;
         cnt <= '0;
      end else begin
         case (st)
            CH_RUN: begin
               cnt <= '0;
               if (deep_idle) begin
                  st <= CH_SWAKE;
               end else if (ref_pend || ref_req) begin
                  st <= CH_WAKE;
               end
            end
            CH_WAKE: begin
               cnt <= '0;
               if (all_up) st <= CH_PRE;
            end
            CH_PRE: begin
               if (cnt == PRE_LAST) begin
                  st  <= CH_REF;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            CH_REF: begin
               st  <= CH_RWAIT;
               cnt <= '0;
            end
            CH_RWAIT: begin
               if (cnt == REF_LAST) begin
                  st <= CH_RUN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            CH_SWAKE: begin
               cnt <= '0;
               if (all_up) st <= CH_SPRE;
            end
            CH_SPRE: begin
               if (cnt == PRE_LAST) begin
                  st  <= CH_SHOLD;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            CH_SHOLD: begin
               cnt <= '0;
               if (!deep_idle) st <= CH_SEXIT;
            end
            CH_SEXIT: begin
               if (cnt == EXIT_LAST) begin
                  st <= CH_RUN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= CH_RUN;
         endcase
      end
   end

   assign run      = (st == CH_RUN);
   assign wake     = (st != CH_RUN);
   assign sleep    = (st == CH_RWAIT) && (cnt == REF_LAST);
   assign chan_pre = ((st == CH_PRE) || (st == CH_SPRE)) && (cnt == '0);
   assign ref_cmd  = (st == CH_REF);
   assign sr_hold  = (st == CH_SHOLD);
   assign sr_exit  = (st == CH_SEXIT);

endmodule

// File: rtl/rank_pd_seq.sv
module rank_pd_seq #(
   parameter int NUM_RANKS = 2,
   parameter int IDLE_W    = 8,
   parameter int EXIT_DLY  = 3,
   parameter int PRE_DLY   = 2,
   parameter int REF_DLY   = 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RANKS-1:0] rank_present,
   input  logic                 pd_precharge,
   input  logic [IDLE_W-1:0]    idle_limit,
   input  logic                 ref_req,
   input  logic                 deep_idle,
   input  logic [NUM_RANKS-1:0] rank_busy,
   output logic [NUM_RANKS-1:0] cke,
   output logic [NUM_RANKS-1:0] cs_en,
   output logic [NUM_RANKS-1:0] pre_all,
   output logic                 ref_cmd,
   output logic                 sr_req,
   output logic [NUM_RANKS-1:0] rank_ready
);

   // elaboration-time parameter checks
   if (NUM_RANKS < 1) begin : g_bad_ranks
      $error("rank_pd_seq: NUM_RANKS must be at least 1");
   end
   if (IDLE_W < 1) begin : g_bad_idle
      $error("rank_pd_seq: IDLE_W must be at least 1");
   end
   if (EXIT_DLY < 1 || PRE_DLY < 1 || REF_DLY < 1) begin : g_bad_dly
      $error("rank_pd_seq: every fixed wait must be at least one cycle");
   end

   logic [NUM_RANKS-1:0] rk_cke;
   logic [NUM_RANKS-1:0] rk_up;
   logic [NUM_RANKS-1:0] rk_in_pre;
   logic [NUM_RANKS-1:0] rk_pre_pulse;
   logic                 all_up;
   logic                 wake;
   logic                 sleep;
   logic                 chan_pre;
   logic                 run;
   logic                 sr_hold;
   logic                 sr_exit;

   // empty slots never hold up a channel sequence
   assign all_up = &(rk_up | ~rank_present);

   pdseq_chan #(
      .EXIT_DLY (EXIT_DLY),
      .PRE_DLY  (PRE_DLY),
      .REF_DLY  (REF_DLY)
   ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_req   (ref_req),
      .deep_idle (deep_idle),
      .all_up    (all_up),
      .wake      (wake),
      .sleep     (sleep),
      .chan_pre  (chan_pre),
      .ref_cmd   (ref_cmd),
      .run       (run),
      .sr_hold   (sr_hold),
      .sr_exit   (sr_exit)
   );

   for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
      pdseq_rank #(
         .IDLE_W   (IDLE_W),
         .EXIT_DLY (EXIT_DLY),
         .PRE_DLY  (PRE_DLY)
      ) u_rank (
         .clk          (clk),
         .rst_n        (rst_n),
         .busy         (rank_busy[i]),
         .pd_precharge (pd_precharge),
         .idle_limit   (idle_limit),
         .wake         (wake),
         .sleep        (sleep),
         .rank_cke     (rk_cke[i]),
         .rank_up      (rk_up[i]),
         .rank_in_pre  (rk_in_pre[i]),
         .pre_pulse    (rk_pre_pulse[i])
      );

      assign cke[i]        = rank_present[i] & ~sr_hold & (sr_exit | rk_cke[i]);
      assign cs_en[i]      = rank_present[i] & ~sr_hold & ~sr_exit & (rk_up[i] | rk_in_pre[i]);
      assign pre_all[i]    = rank_present[i] & ~sr_hold & (rk_pre_pulse[i] | chan_pre);
      assign rank_ready[i] = rank_present[i] & rk_up[i] & rank_busy[i] & run;
   end

   assign sr_req = sr_hold;

endmodule

// File: rtl/rank_pd_seq_chk.sv
module rank_pd_seq_chk #(
   parameter int NUM_RANKS = 2
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_RANKS-1:0] rank_present,
   input logic [NUM_RANKS-1:0] cke,
   input logic [NUM_RANKS-1:0] cs_en,
   input logic [NUM_RANKS-1:0] pre_all,
   input logic [NUM_RANKS-1:0] rank_ready,
   input logic                 ref_cmd,
   input logic                 sr_req
);

   // R2
   empty_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cke | cs_en | pre_all | rank_ready) & ~rank_present) == '0);

   // R6
   ready_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rank_ready & ~cke) == '0);

   // R6
   cs_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_en & ~cke) == '0);

   // R7
   ref_all_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |-> ((cke & rank_present) == rank_present));

   // R7
   ref_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |=> !ref_cmd);

   // R9
   sr_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_req |-> (cke == '0));

   // R11
   sr_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_req |-> (rank_ready == '0));

   // R9
   sr_no_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_req |-> !ref_cmd);

   // R10
   sr_exit_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_req) |-> ((cke & rank_present) == rank_present));

   for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rk
      // R6
      grant_after_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rank_ready[i]) |-> $past(cke[i]));

      // R5
      pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pre_all[i] |=> !pre_all[i]);
   end

endmodule

bind rank_pd_seq rank_pd_seq_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rank_present (rank_present),
   .cke          (cke),
   .cs_en        (cs_en),
   .pre_all      (pre_all),
   .rank_ready   (rank_ready),
   .ref_cmd      (ref_cmd),
   .sr_req       (sr_req)
);

// File: tb/tb_rank_pd_seq.sv
module tb_rank_pd_seq;

   localparam int NR       = 2;
   localparam int IW       = 8;
   localparam int EXIT_DLY = 3;
   localparam int PRE_DLY  = 2;
   localparam int REF_DLY  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NR-1:0] present;
   logic          pd_pre;
   logic [IW-1:0] idle_limit;
   logic          ref_req;
   logic          deep_idle;
   logic [NR-1:0] busy;
   logic [NR-1:0] cke;
   logic [NR-1:0] cs_en;
   logic [NR-1:0] pre_all;
   logic          ref_cmd;
   logic          sr_req;
   logic [NR-1:0] rank_ready;

   int n_chk = 0;
   int n_err = 0;
   bit mon_on = 1'b0;
   int r2_bad = 0;

   always #10 clk = ~clk;

   rank_pd_seq #(
      .NUM_RANKS (NR),
      .IDLE_W    (IW),
      .EXIT_DLY  (EXIT_DLY),
      .PRE_DLY   (PRE_DLY),
      .REF_DLY   (REF_DLY)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rank_present (present),
      .pd_precharge (pd_pre),
      .idle_limit   (idle_limit),
      .ref_req      (ref_req),
      .deep_idle    (deep_idle),
      .rank_busy    (busy),
      .cke          (cke),
      .cs_en        (cs_en),
      .pre_all      (pre_all),
      .ref_cmd      (ref_cmd),
      .sr_req       (sr_req),
      .rank_ready   (rank_ready)
   );

   function automatic int exp_idle(input int lim);
      return (lim == 0) ? 1 : lim;
   endfunction

   function automatic int exp_entry(input int lim, input bit m);
      return exp_idle(lim) + (m ? PRE_DLY : 0);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // R2 monitor: empty slots must stay quiet
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (((cke | cs_en | pre_all | rank_ready) & ~present) != '0) r2_bad++;
      end
   end

   task automatic measure_entry(input int r, input int lim, input bit m);
      int n; int pre_at; int pre_cnt; int cke_at; int rdy_at; int bad; bit from_pd;
      @(negedge clk);
      idle_limit = IW'(lim);
      pd_pre     = m;
      from_pd    = !cke[r];
      busy[r]    = 1'b1;
      n = 0; cke_at = -1; rdy_at = -1; bad = 0;
      while (rdy_at < 0 && n < 40) begin
         @(posedge clk); n++; @(negedge clk);
         if (cke[r] && cke_at < 0) cke_at = n;
         if (rank_ready[r]) rdy_at = n;
         if (rank_ready[r] && !cke[r]) bad++;
      end
      if (from_pd) begin
         chk(cke_at == 1, "R6", "cke rise after access", cke_at, 1);
         chk(rdy_at == EXIT_DLY + 1, "R6", "grant after exit delay", rdy_at, EXIT_DLY + 1);
         chk(bad == 0, "R6", "grant with cke low", bad, 0);
      end else begin
         chk(rdy_at > 0, "R6", "grant for awake rank", rdy_at, 1);
      end
      repeat (2) @(negedge clk);
      busy[r] = 1'b0;
      n = 0; pre_at = -1; pre_cnt = 0; cke_at = -1;
      while (cke_at < 0 && n < 60) begin
         @(posedge clk); n++; @(negedge clk);
         if (pre_all[r]) begin
            pre_cnt++;
            if (pre_at < 0) pre_at = n;
         end
         if (!cke[r]) cke_at = n;
      end
      if (m) begin
         chk(cke_at == exp_entry(lim, m), "R5", "cke drop edge (precharge mode)", cke_at, exp_entry(lim, m));
         chk(pre_at == exp_idle(lim), "R5", "precharge-all edge", pre_at, exp_idle(lim));
         chk(pre_cnt == 1, "R5", "precharge-all cycles", pre_cnt, 1);
      end else begin
         chk(cke_at == exp_entry(lim, m), "R3", "cke drop edge (active mode)", cke_at, exp_entry(lim, m));
         chk(pre_cnt == 0, "R4", "no precharge-all in active mode", pre_cnt, 0);
      end
   endtask

   task automatic do_refresh();
      int n; bit pre_ok; int rc_at;
      @(negedge clk);
      ref_req = 1'b1;
      @(negedge clk);
      ref_req = 1'b0;
      n = 0; pre_ok = 1'b0; rc_at = -1;
      while (rc_at < 0 && n < 60) begin
         if ((pre_all & present) == present) pre_ok = 1'b1;
         if (ref_cmd) rc_at = n;
         else begin
            @(posedge clk); n++; @(negedge clk);
         end
      end
      chk(rc_at >= 0, "R7", "refresh command issued", (rc_at >= 0) ? 1 : 0, 1);
      chk((cke & present) == present, "R7", "ranks awake at refresh", int'(cke), int'(present));
      chk(pre_ok, "R7", "precharge-all before refresh", int'(pre_ok), 1);
      for (int k = 1; k <= REF_DLY + 1; k++) begin
         @(posedge clk); @(negedge clk);
         if (k == 1) chk(!ref_cmd, "R7", "refresh is one cycle", int'(ref_cmd), 0);
         if (k == REF_DLY) chk((cke & present) == present, "R8", "awake in refresh wait", int'(cke), int'(present));
         if (k == REF_DLY + 1) chk((cke & present) == '0, "R8", "powered down after refresh", int'(cke), 0);
      end
   endtask

   task automatic do_sr(input int r);
      int n; int rc; int rd; int fall; int up; int rdy;
      @(negedge clk);
      deep_idle = 1'b1;
      n = 0;
      while (!sr_req && n < 60) begin
         @(posedge clk); n++; @(negedge clk);
      end
      chk(sr_req, "R9", "self-refresh requested", int'(sr_req), 1);
      chk(cke == '0, "R9", "all cke low in self-refresh", int'(cke), 0);
      busy[r] = 1'b1;
      ref_req = 1'b1;
      @(negedge clk);
      ref_req = 1'b0;
      rc = 0; rd = 0;
      repeat (8) begin
         @(posedge clk); @(negedge clk);
         if (ref_cmd) rc++;
         if (rank_ready != '0) rd++;
      end
      chk(rc == 0, "R9", "refresh ignored in self-refresh", rc, 0);
      chk(rd == 0, "R11", "no grant in self-refresh", rd, 0);
      deep_idle = 1'b0;
      n = 0; fall = -1; up = -1; rdy = -1;
      while (rdy < 0 && n < 40) begin
         @(posedge clk); n++; @(negedge clk);
         if (!sr_req && fall < 0) fall = n;
         if ((cke & present) == present && up < 0) up = n;
         if (rank_ready[r]) rdy = n;
      end
      chk(fall == 1, "R10", "self-refresh request drop", fall, 1);
      chk(up == 1, "R10", "ranks raised on exit", up, 1);
      chk(rdy == EXIT_DLY + 1, "R10", "grant after self-refresh exit", rdy, EXIT_DLY + 1);
      rc = 0;
      repeat (10) begin
         @(posedge clk); @(negedge clk);
         if (ref_cmd) rc++;
      end
      chk(rc == 0, "R9", "stale refresh after exit", rc, 0);
      busy[r] = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D1E5EED));
      rst_n      = 1'b0;
      present    = 2'b11;
      pd_pre     = 1'b0;
      idle_limit = IW'(5);
      ref_req    = 1'b0;
      deep_idle  = 1'b0;
      busy       = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cke == 2'b11, "R1", "cke in reset", int'(cke), 3);
      chk(cs_en == 2'b11, "R1", "cs_en in reset", int'(cs_en), 3);
      chk(pre_all == '0 && !ref_cmd && !sr_req && rank_ready == '0, "R1",
          "no requests in reset", int'({pre_all, ref_cmd, sr_req, rank_ready}), 0);
      rst_n = 1'b1;

      // directed corners: limit 0 in both modes, limit 1 precharge
      measure_entry(0, 0, 1'b0);
      measure_entry(1, 0, 1'b1);
      measure_entry(0, 1, 1'b1);

      // constrained random entry and wake
      for (int it = 0; it < 12; it++) begin
         measure_entry(int'($urandom % NR), int'($urandom % 10), 1'(($urandom % 2)));
      end

      // refresh with both ranks asleep
      busy = '0;
      idle_limit = IW'(3);
      pd_pre = 1'b0;
      repeat (20) @(negedge clk);
      do_refresh();

      // self-refresh with both ranks
      do_sr(0);

      // R2: slot 1 empty
      @(negedge clk);
      present = 2'b01;
      mon_on  = 1'b1;
      repeat (20) begin
         @(negedge clk);
         busy[1] = 1'($urandom % 2);
      end
      busy = '0;
      repeat (20) @(negedge clk);
      do_refresh();
      do_sr(0);

      // R2: slot 0 empty
      @(negedge clk);
      present = 2'b10;
      busy    = 2'b01;
      repeat (10) @(negedge clk);
      busy = '0;
      repeat (20) @(negedge clk);
      do_refresh();
      do_sr(1);
      mon_on = 1'b0;
      chk(r2_bad == 0, "R2", "empty slot outputs asserted", r2_bad, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule